// File: doc/BRIEF.md
# Sequential Grant Coordinator

This block hands a single permission token to a fixed set of ports, one after another. Each port has a grant output and a release input. The order in which ports receive grant is fixed when the block is built: each port has a turn number. The port with turn 0 goes first, then turn 1, and so on. A port that sees its grant high may start issuing its own transactions to a shared target. When it has finished, it pulses its release line. On that pulse, the token moves on to the port with the next turn number.

The coordinator only advises the ports. It sits beside the data path and never gates it. A port that transmits without holding grant cannot be stopped here. Releases from ports that do not hold grant are ignored. After the last turn releases, no grant is issued again, and a done flag stays high until the next reset. A new reset starts the sequence again from turn 0.

Top module: `grant_coordinator`

## Requirements
- R1: While `rst_n` is low, `grant_o` is all zeros and `done_o` is 0.
- R2: At the first rising clock edge after `rst_n` goes high, `grant_o` becomes the one-hot bit of the port whose turn number is 0.
- R3: Port `p` has turn number `TURN_OF_PORT[p*TURN_W +: TURN_W]`. The turn numbers form a permutation of 0 to N_PORTS-1. Grants are issued in rising turn-number order.
- R4: While the granted port keeps its `release_i` bit low, `grant_o` does not change.
- R5: If the granted port's `release_i` bit is high at a rising edge, and that port's turn is not the last one, then from that edge `grant_o` holds the one-hot bit of the next turn's port. There is no gap cycle between the two grants.
- R6: A `release_i` bit from a port that does not hold grant is ignored. This holds even when it arrives in the same cycle as the holder's release, so the grant advances by exactly one turn.
- R7: `grant_o` never has more than one bit set.
- R8: When the port with the last turn releases, `grant_o` becomes all zeros and `done_o` goes to 1 at that edge. Both stay that way until reset, whatever `release_i` does.
- R9: A later reset followed by release restarts the sequence at turn 0, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, is released synchronously to `clk` |
| release_i | input | N_PORTS | One bit per port: the holder's bit high for a cycle hands the token on |
| grant_o | output | N_PORTS | One-hot (or zero) permission to the port whose turn it is |
| done_o | output | 1 | High once every turn has been released; stays high until reset |

## Verification
The case that needs care is a handover that coincides with a stray release. In that cycle the current holder releases, and the port next in line (or any other port) also drives its release bit. The bench provokes it by driving, for one cycle, the holder's bit and the next-in-line port's bit together. It then keeps all releases low and requires the grant to sit on the next-in-line port. The grant must not jump past that port, because the stray pulse has to be discarded rather than stored. The last-turn release is also checked against a flood of releases from every port. After it, `done_o` must stay high and `grant_o` must stay zero.

// File: rtl/tc_pkg.sv
package tc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2
  } tc_state_e;

  function automatic int tc_turn_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tc_turn_map.sv
// Decodes the per-port turn numbers into one one-hot port mask per turn.
module tc_turn_map #(
  parameter int N_PORTS = 4,
  parameter int TURN_W  = 2,
  parameter logic [N_PORTS*TURN_W-1:0] TURN_OF_PORT = '0
) (
  output logic [N_PORTS-1:0][N_PORTS-1:0] turn_mask_o
);

  for (genvar t = 0; t < N_PORTS; t++) begin : g_turn
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      assign turn_mask_o[t][p] =
        (TURN_OF_PORT[p*TURN_W +: TURN_W] == TURN_W'(t));
    end
  end

endmodule

// File: rtl/tc_release_pick.sv
// Keeps only the release coming from the port that currently holds grant.
module tc_release_pick #(
  parameter int N_PORTS = 4
) (
  input  logic [N_PORTS-1:0] grant_i,
  input  logic [N_PORTS-1:0] release_i,
  output logic               holder_rel_o
);

  assign holder_rel_o = |(grant_i & release_i);

endmodule

// File: rtl/tc_sequencer.sv
// Turn counter and registered grant / done state.
module tc_sequencer
  import tc_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int TURN_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N_PORTS-1:0][N_PORTS-1:0] turn_mask_i,
  input  logic                            holder_rel_i,
  output logic [N_PORTS-1:0]              grant_o,
  output logic                            done_o
);

  localparam logic [TURN_W-1:0] LAST_TURN = TURN_W'(N_PORTS - 1);

  tc_state_e          state_q, state_d;
  logic [TURN_W-1:0]  turn_q, turn_d, turn_inc;
  logic [N_PORTS-1:0] grant_q, grant_d;
  logic               done_q, done_d;
  logic               adv_en;

  assign turn_inc = turn_q + TURN_W'(1);

  // clock enable: leave idle once, or move on when the holder lets go
  assign adv_en = (state_q == ST_IDLE) ||
                  ((state_q == ST_HOLD) && holder_rel_i);

  always_comb begin
    state_d = state_q;
    turn_d  = turn_q;
    grant_d = grant_q;
    done_d  = done_q;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_HOLD;
        turn_d  = '0;
        grant_d = turn_mask_i[0];
      end
      ST_HOLD: begin
        if (turn_q == LAST_TURN) begin
          state_d = ST_DONE;
          grant_d = '0;
          done_d  = 1'b1;
        end else begin
          turn_d  = turn_inc;
          grant_d = turn_mask_i[turn_inc];
        end
      end
      default: begin
        state_d = ST_DONE;
        grant_d = '0;
        done_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      turn_q  <= '0;
      grant_q <= '0;
      done_q  <= 1'b0;
    end else if (adv_en) begin
      state_q <= state_d;
      turn_q  <= turn_d;
      grant_q <= grant_d;
      done_q  <= done_d;
    end
  end

  assign grant_o = grant_q;
  assign done_o  = done_q;

endmodule

// File: rtl/grant_coordinator.sv
// Fixed-order grant sequencer: one port at a time, advanced on release.
module grant_coordinator #(
  parameter  int N_PORTS = 4,
  localparam int TURN_W  = tc_pkg::tc_turn_width(N_PORTS),
  // port p has turn TURN_OF_PORT[p*TURN_W +: TURN_W]
  parameter  logic [N_PORTS*TURN_W-1:0] TURN_OF_PORT = 8'b01_11_00_10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] release_i,
  output logic [N_PORTS-1:0] grant_o,
  output logic               done_o
);

  logic [N_PORTS-1:0][N_PORTS-1:0] turn_mask;
  logic                            holder_rel;
  logic [N_PORTS-1:0]              grant_int;

  tc_turn_map #(
    .N_PORTS      (N_PORTS),
    .TURN_W       (TURN_W),
    .TURN_OF_PORT (TURN_OF_PORT)
  ) u_turn_map (
    .turn_mask_o (turn_mask)
  );

  tc_release_pick #(
    .N_PORTS (N_PORTS)
  ) u_release_pick (
    .grant_i      (grant_int),
    .release_i    (release_i),
    .holder_rel_o (holder_rel)
  );

  tc_sequencer #(
    .N_PORTS (N_PORTS),
    .TURN_W  (TURN_W)
  ) u_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .turn_mask_i  (turn_mask),
    .holder_rel_i (holder_rel),
    .grant_o      (grant_int),
    .done_o       (done_o)
  );

  assign grant_o = grant_int;

endmodule

// File: rtl/grant_coordinator_checker.sv
module grant_coordinator_checker #(
  parameter int N_PORTS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] release_i,
  input logic [N_PORTS-1:0] grant_o,
  input logic               done_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R2, R9: first edge out of reset produces a grant
  assert_first_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |=> (grant_o != '0));

  // R4, R6: no holder release, no movement
  assert_hold_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o != '0) && ((grant_o & release_i) == '0)) |=> $stable(grant_o));

  // R5: holder release moves the grant
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & release_i) != '0) |=> (grant_o != $past(grant_o)));

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && (grant_o == '0)));

  assert_done_no_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && (grant_o != '0)));

endmodule

bind grant_coordinator grant_coordinator_checker #(
  .N_PORTS (N_PORTS)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .release_i (release_i),
  .grant_o   (grant_o),
  .done_o    (done_o)
);

// File: tb/grant_coordinator_bench.sv
`timescale 1ns/1ps
module grant_coordinator_bench;

  localparam int N = 4;
  localparam int TW = 2;
  localparam logic [N*TW-1:0] TURNS = 8'b01_11_00_10; // order: p1,p3,p0,p2

  logic         clk;
  logic         rst_n;
  logic [N-1:0] rel;
  logic [N-1:0] grant;
  logic         done;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  grant_coordinator #(.N_PORTS(N), .TURN_OF_PORT(TURNS)) u_grant_coordinator (
    .clk(clk), .rst_n(rst_n), .release_i(rel), .grant_o(grant), .done_o(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] port_bit(input int turn);
    logic [N-1:0] m = '0;
    for (int p = 0; p < N; p++)
      if (int'(TURNS[p*TW +: TW]) == turn) m[p] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input logic [N-1:0] exp_g, input logic exp_d);
    n_checks++;
    if (grant !== exp_g || done !== exp_d || $countones(grant) > 1) begin
      n_fails++;
      $display("FAIL %s: grant=%b done=%b expected grant=%b done=%b",
               req, grant, done, exp_g, exp_d);
    end
  endtask

  task automatic pulse(input logic [N-1:0] v);
    @(negedge clk) rel = v;
    @(negedge clk) rel = '0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; rel = '0;
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);
  endtask

  task automatic t_first_grant(input string req);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(req, port_bit(0), 1'b0);
  endtask

  task automatic t_hold_ignore_strays();
    for (int c = 0; c < 3; c++) begin
      @(negedge clk) rel = ~port_bit(0);
      @(negedge clk);
      check("R6", port_bit(0), 1'b0);
    end
    rel = '0;
    repeat (2) @(negedge clk);
    check("R4", port_bit(0), 1'b0);
  endtask

  task automatic t_handover_with_stray();
    pulse(port_bit(0) | port_bit(1));
    check("R5", port_bit(1), 1'b0);
    repeat (2) @(negedge clk);
    check("R6", port_bit(1), 1'b0);
  endtask

  task automatic t_walk();
    for (int t = 1; t < N - 1; t++) begin
      pulse(port_bit(t));
      check("R3", port_bit(t + 1), 1'b0);
    end
  endtask

  task automatic t_last_and_done();
    pulse(port_bit(N - 1));
    check("R8", '0, 1'b1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk) rel = '1;
      @(negedge clk);
      check("R8", '0, 1'b1);
    end
    rel = '0;
  endtask

  initial begin
    rst_n = 1'b0; rel = '0;
    t_reset_state();
    t_first_grant("R2");
    t_hold_ignore_strays();
    t_handover_with_stray();
    t_walk();
    t_last_and_done();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1", '0, 1'b0);
    t_first_grant("R9");
    pulse(port_bit(0));
    check("R9", port_bit(1), 1'b0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule